// File: doc/BRIEF.md
# Power-Management Event Status and Timer Unit

This block keeps the 16-bit power-management event status word and its matching 16-bit enable word. It runs a free-running timer that advances on a tick-enable strobe. It combines the enabled events with an external general-purpose event request into one level-sensitive system control interrupt (`sci`). Software reaches the block through a small register bus. The bus has a write strobe, a byte offset, 16-bit write data and a combinational 32-bit read path.

The timer status flag fires each time the counter reaches an overflow threshold. The threshold always lies on a multiple of half the visible timer range. After the flag fires, the threshold is not advanced again until software clears the flag. The clear loads the next boundary above the count current at that moment. Power-button, real-time-clock, global-lock and wake events arrive as one-cycle pulses from neighbouring logic.

Top module: `pm1_event_unit`

## Requirements
- R1: A synchronous active-low reset clears the status word, the enable word, the counter and the overflow threshold. Because the threshold is then 0, the timer status flag (bit 0) becomes 1 on the first clock edge after reset is released.
- R2: The counter increments by one on each clock edge where `tick_en` is high and holds otherwise. A read at offset 0x08 returns the counter's low VIEW_W bits (default 24) in bits [VIEW_W-1:0], with the upper bits zero. Writes to 0x08 have no effect.
- R3: Status bit 0 is set on the edge after the counter equals or passes the threshold. The comparison is modular over the VIEW_W+1 bit counter, so a threshold that has wrapped to 0 is reached only when the counter itself wraps.
- R4: A status write with data bit 0 = 1, while bit 0 is set or being set, loads a new threshold. The new value is (count + 2^(VIEW_W-1)) rounded down to a multiple of 2^(VIEW_W-1), modulo 2^(VIEW_W+1). In that cycle the clear takes priority over a new set of bit 0.
- R5: A write at offset 0x00 clears each status bit written as 1 and leaves bits written as 0 unchanged. If an event pulse for bit 5, 8, 10 or 15 arrives in the same cycle as a clear of that bit, the bit stays set.
- R6: A write at offset 0x02 loads all 16 data bits into the enable word. A read at 0x02 returns that word.
- R7: A `pwrbtn_evt` pulse sets status bit 8 only if enable bit 8 is 1. Otherwise the pulse is dropped.
- R8: An `rtc_evt` pulse sets status bit 10, a `glock_evt` pulse sets bit 5 and a `wake_set` pulse sets bit 15. None of these depends on the enable word.
- R9: `sci` is high when status AND enable has any of bits 0, 5, 8 or 10 set, or when `gpe_req` is high. `gpe_req` acts combinationally, and status bit 15 never drives `sci`.
- R10: Reads of any offset other than 0x00, 0x02 and 0x08 return zero. Writes to any other offset change neither word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tick_en | input | 1 | Timer advance strobe |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| rtc_evt | input | 1 | Real-time-clock event pulse |
| glock_evt | input | 1 | Global-lock event pulse |
| wake_set | input | 1 | Wake status set pulse from the sleep controller |
| gpe_req | input | 1 | External general-purpose event request level |
| sci | output | 1 | System control interrupt level |

## Verification
A wrong threshold has two visible symptoms. Status bit 0 may rise a cycle early or late relative to the count read at 0x08. Or it may rise at once after a clear that should have rearmed it. The bench steps the counter to one short of each expected boundary and then onto it, including a boundary that wraps to zero, so an off-by-one threshold fails within one tick. A corrupted status or enable bit appears at once on the 0x00 or 0x02 read and on `sci` one edge after the stimulus. The bench therefore reads both words and samples `sci` after every event, clear and enable write.

// File: rtl/pm1_pkg.sv
// Package: shared bit positions, offsets and event bundle for the PM1 unit.
// Assumes a 16-bit status/enable layout and a 32-bit read path.
package pm1_pkg;

    localparam int unsigned TMR_BIT = 0;
    localparam int unsigned GLK_BIT = 5;
    localparam int unsigned PWR_BIT = 8;
    localparam int unsigned RTC_BIT = 10;
    localparam int unsigned WAK_BIT = 15;

    localparam int REG_W = 16;
    localparam int RD_W  = 32;

    localparam int OFS_STS = 'h0;
    localparam int OFS_EN  = 'h2;
    localparam int OFS_TMR = 'h8;

    // Status bits that may raise the interrupt when enabled.
    localparam logic [REG_W-1:0] SCI_MASK =
        (REG_W'(1) << TMR_BIT) | (REG_W'(1) << GLK_BIT) |
        (REG_W'(1) << PWR_BIT) | (REG_W'(1) << RTC_BIT);

    typedef struct packed {
        logic wake;
        logic rtc;
        logic pwr;
        logic glk;
    } pm1_evt_t;

endpackage

// File: rtl/pm_tick_timer.sv
// Module: free-running tick counter plus the overflow threshold.
// ovf_hit is high while the count has reached the threshold, judged modulo
// the counter width. rearm loads the next half-range boundary above the
// current count. Assumes the threshold is never more than half the counter
// range ahead of the count.
module pm_tick_timer #(
    parameter int VIEW_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              rearm,
    output logic [VIEW_W-1:0] cnt_view,
    output logic              ovf_hit
);

    localparam int CNT_W   = VIEW_W + 1;
    localparam int STEP_SH = VIEW_W - 1;
    localparam logic [CNT_W-1:0] STEP     = CNT_W'(1) << STEP_SH;
    localparam logic [CNT_W-1:0] LOW_MASK = STEP - CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] gap;
    logic [CNT_W-1:0] thr_nxt;

    // Purpose: signed distance of the count past the threshold, and the next boundary.
    always_comb begin
        gap     = cnt_q - thr_q;
        thr_nxt = (cnt_q + STEP) & ~LOW_MASK;
    end

    assign ovf_hit  = ~gap[CNT_W-1];
    assign cnt_view = cnt_q[VIEW_W-1:0];

    // Purpose: advance the counter on each tick strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Purpose: hold the overflow threshold and reload it on a rearm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (rearm) begin
            thr_q <= thr_nxt;
        end
    end

    assert_tick_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    assert_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));

    assert_rearm_ahead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm && !tick_en) |=> !ovf_hit);

endmodule

// File: rtl/pm1_evt_regs.sv
// Module: status and enable words.
// Status bits are write-1-to-clear. Event pulses beat a clear of their own
// bit. The timer flag is the exception: its clear beats its set and asks the
// timer to rearm. Assumes sts_wr and en_wr are never both high.
module pm1_evt_regs
    import pm1_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sts_wr,
    input  logic             en_wr,
    input  logic [REG_W-1:0] wdata,
    input  pm1_evt_t         evt,
    input  logic             ovf_hit,
    output logic [REG_W-1:0] sts_q,
    output logic [REG_W-1:0] en_q,
    output logic             rearm
);

    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] set_vec;

    // Purpose: form the per-bit clear and set requests for this cycle.
    always_comb begin
        clr_vec          = sts_wr ? wdata : '0;
        set_vec          = '0;
        set_vec[TMR_BIT] = ovf_hit & ~clr_vec[TMR_BIT];
        set_vec[GLK_BIT] = evt.glk;
        set_vec[PWR_BIT] = evt.pwr & en_q[PWR_BIT];
        set_vec[RTC_BIT] = evt.rtc;
        set_vec[WAK_BIT] = evt.wake;
    end

    assign rearm = sts_wr & wdata[TMR_BIT] & (sts_q[TMR_BIT] | ovf_hit);

    // Purpose: update the status word from clears and set requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_vec) | set_vec;
        end
    end

    // Purpose: load the enable word from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= wdata;
        end
    end

    assert_pwr_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt.pwr && en_q[PWR_BIT]) |=> !$rose(sts_q[PWR_BIT]));

    assert_tmr_only_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_hit |=> !$rose(sts_q[TMR_BIT]));

    assert_tmr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && wdata[TMR_BIT]) |=> !sts_q[TMR_BIT]);

    assert_wake_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt.wake |=> sts_q[WAK_BIT]);

    assert_en_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> en_q == $past(wdata));

endmodule

// File: rtl/pm1_bus_port.sv
// Module: register bus decode and read multiplexer.
// Writes are decoded against the exact offset. The read path is
// combinational from bus_addr. Unmapped offsets read zero.
module pm1_bus_port
    import pm1_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int VIEW_W = 24
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  sts_q,
    input  logic [REG_W-1:0]  en_q,
    input  logic [VIEW_W-1:0] cnt_view,
    output logic              sts_wr,
    output logic              en_wr,
    output logic [RD_W-1:0]   bus_rdata
);

    logic hit_sts;
    logic hit_en;
    logic hit_tmr;

    // Purpose: match the offset against the three mapped registers.
    always_comb begin
        hit_sts = (bus_addr == ADDR_W'(OFS_STS));
        hit_en  = (bus_addr == ADDR_W'(OFS_EN));
        hit_tmr = (bus_addr == ADDR_W'(OFS_TMR));
    end

    assign sts_wr = bus_wr & hit_sts;
    assign en_wr  = bus_wr & hit_en;

    // Purpose: select the read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (hit_sts) begin
            bus_rdata = RD_W'(sts_q);
        end else if (hit_en) begin
            bus_rdata = RD_W'(en_q);
        end else if (hit_tmr) begin
            bus_rdata = RD_W'(cnt_view);
        end
    end

endmodule

// File: rtl/pm1_event_unit.sv
// Module: top of the power-management event unit.
// Ties the bus port, status/enable registers and tick timer together and
// forms the interrupt level. Assumes event inputs are synchronous to clk.
module pm1_event_unit
    import pm1_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int VIEW_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_en,
    input  logic              pwrbtn_evt,
    input  logic              rtc_evt,
    input  logic              glock_evt,
    input  logic              wake_set,
    input  logic              gpe_req,
    output logic              sci
);

    logic             sts_wr;
    logic             en_wr;
    logic             rearm;
    logic             ovf_hit;
    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] en_q;
    logic [VIEW_W-1:0] cnt_view;
    pm1_evt_t         evt;

    assign evt = '{wake: wake_set, rtc: rtc_evt, pwr: pwrbtn_evt, glk: glock_evt};

    pm1_bus_port #(.ADDR_W(ADDR_W), .VIEW_W(VIEW_W)) u_port (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .sts_q     (sts_q),
        .en_q      (en_q),
        .cnt_view  (cnt_view),
        .sts_wr    (sts_wr),
        .en_wr     (en_wr),
        .bus_rdata (bus_rdata)
    );

    pm1_evt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sts_wr  (sts_wr),
        .en_wr   (en_wr),
        .wdata   (bus_wdata),
        .evt     (evt),
        .ovf_hit (ovf_hit),
        .sts_q   (sts_q),
        .en_q    (en_q),
        .rearm   (rearm)
    );

    pm_tick_timer #(.VIEW_W(VIEW_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .rearm    (rearm),
        .cnt_view (cnt_view),
        .ovf_hit  (ovf_hit)
    );

    // Purpose: interrupt level from enabled pending events or the external request.
    always_comb begin
        sci = (|(sts_q & en_q & SCI_MASK)) | gpe_req;
    end

    assert_gpe_drives_sci_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gpe_req |-> sci);

    assert_wake_no_sci_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gpe_req && ((sts_q & en_q & ~(REG_W'(1) << WAK_BIT)) == '0)) |-> !sci);

endmodule

// File: tb/tb_pm1_event_unit.sv
module tb_pm1_event_unit;

    localparam int CLK_PERIOD = 10;
    localparam int VW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        pwrbtn_evt = 1'b0;
    logic        rtc_evt = 1'b0;
    logic        glock_evt = 1'b0;
    logic        wake_set = 1'b0;
    logic        gpe_req = 1'b0;
    logic        sci;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm1_event_unit #(.ADDR_W(4), .VIEW_W(VW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .pwrbtn_evt(pwrbtn_evt), .rtc_evt(rtc_evt), .glock_evt(glock_evt),
        .wake_set(wake_set), .gpe_req(gpe_req), .sci(sci)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic chk_sci(input string req, input logic exp);
        #1;
        check(req, {31'b0, sci}, {31'b0, exp});
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_rd("R1 sts in reset", 4'h0, 32'h0);
        chk_rd("R1 en in reset", 4'h2, 32'h0);
        chk_rd("R1 count in reset", 4'h8, 32'h0);
        rst_n = 1'b1;
        idle();
        chk_rd("R1 timer flag after release", 4'h0, 32'h0001);
        chk_rd("R2 count held without tick", 4'h8, 32'h0);
    endtask

    task automatic test_rearm();
        wr(4'h0, 16'h0001);
        chk_rd("R4 flag cleared", 4'h0, 32'h0);
        ticks(127);
        chk_rd("R2 count 127", 4'h8, 32'd127);
        idle();
        chk_rd("R3 no flag before boundary", 4'h0, 32'h0);
        ticks(1);
        idle();
        chk_rd("R3 flag at boundary 128", 4'h0, 32'h0001);
        chk_rd("R2 count 128", 4'h8, 32'd128);
    endtask

    task automatic test_rounding();
        ticks(50);
        wr(4'h0, 16'h0001);
        chk_rd("R4 cleared at count 178", 4'h0, 32'h0);
        ticks(77);
        idle();
        chk_rd("R4 rounded threshold not yet at 255", 4'h0, 32'h0);
        ticks(1);
        idle();
        chk_rd("R4 flag at rounded threshold 256", 4'h0, 32'h0001);
        chk_rd("R2 view wraps to low bits", 4'h8, 32'h0);
    endtask

    task automatic test_wrap();
        wr(4'h0, 16'h0001);
        ticks(128);
        idle();
        chk_rd("R3 flag at 384", 4'h0, 32'h0001);
        wr(4'h0, 16'h0001);
        ticks(127);
        idle();
        chk_rd("R3 wrapped threshold not reached at 511", 4'h0, 32'h0);
        ticks(1);
        idle();
        chk_rd("R3 wrapped threshold reached at 0", 4'h0, 32'h0001);
        wr(4'h0, 16'h0000);
        chk_rd("R5 zero write leaves flag", 4'h0, 32'h0001);
    endtask

    task automatic test_enable_and_map();
        wr(4'h2, 16'hA5A5);
        chk_rd("R6 enable readback", 4'h2, 32'h0000A5A5);
        chk_sci("R9 timer flag enabled drives sci", 1'b1);
        wr(4'h2, 16'h0000);
        chk_sci("R9 sci low when disabled", 1'b0);
        wr(4'h4, 16'hFFFF);
        chk_rd("R10 unmapped reads zero", 4'h4, 32'h0);
        chk_rd("R10 enable untouched", 4'h2, 32'h0);
        chk_rd("R10 status untouched", 4'h0, 32'h0001);
        wr(4'h8, 16'h1234);
        chk_rd("R2 timer write ignored", 4'h8, 32'h0);
        wr(4'h0, 16'h0001);
        chk_rd("R4 flag cleared before event tests", 4'h0, 32'h0);
    endtask

    task automatic test_pwrbtn();
        @(negedge clk); pwrbtn_evt = 1'b1;
        @(negedge clk); pwrbtn_evt = 1'b0;
        chk_rd("R7 dropped when disabled", 4'h0, 32'h0);
        chk_sci("R7 no sci", 1'b0);
        wr(4'h2, 16'h0100);
        @(negedge clk); pwrbtn_evt = 1'b1;
        @(negedge clk); pwrbtn_evt = 1'b0;
        chk_rd("R7 set when enabled", 4'h0, 32'h0100);
        chk_sci("R9 button sci", 1'b1);
        wr(4'h0, 16'h0100);
        chk_rd("R5 button cleared", 4'h0, 32'h0);
        chk_sci("R9 sci drops", 1'b0);
    endtask

    task automatic test_events();
        @(negedge clk); rtc_evt = 1'b1;
        @(negedge clk); rtc_evt = 1'b0;
        chk_rd("R8 rtc bit", 4'h0, 32'h0400);
        chk_sci("R9 rtc not enabled", 1'b0);
        @(negedge clk); glock_evt = 1'b1;
        @(negedge clk); glock_evt = 1'b0;
        chk_rd("R8 global lock bit", 4'h0, 32'h0420);
        @(negedge clk); wake_set = 1'b1;
        @(negedge clk); wake_set = 1'b0;
        chk_rd("R8 wake bit", 4'h0, 32'h8420);
        wr(4'h2, 16'h8000);
        chk_sci("R9 wake excluded", 1'b0);
        wr(4'h2, 16'h0400);
        chk_sci("R9 rtc enabled", 1'b1);
        wr(4'h2, 16'h0020);
        chk_sci("R9 global lock enabled", 1'b1);
        wr(4'h2, 16'h0000);
        @(negedge clk);
        bus_addr = 4'h0; bus_wdata = 16'h0400; bus_wr = 1'b1; rtc_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rtc_evt = 1'b0;
        chk_rd("R5 event beats clear", 4'h0, 32'h8420);
        wr(4'h0, 16'h8420);
        chk_rd("R5 all cleared", 4'h0, 32'h0);
    endtask

    task automatic test_gpe();
        @(negedge clk); gpe_req = 1'b1;
        chk_sci("R9 gpe raises sci", 1'b1);
        @(negedge clk); gpe_req = 1'b0;
        chk_sci("R9 gpe release", 1'b0);
    endtask

    task automatic test_reset_again();
        wr(4'h2, 16'hFFFF);
        ticks(5);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk_rd("R1 enable cleared", 4'h2, 32'h0);
        chk_rd("R1 count cleared", 4'h8, 32'h0);
        rst_n = 1'b1;
        idle();
        chk_rd("R1 threshold cleared", 4'h0, 32'h0001);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        test_reset();
        test_rearm();
        test_rounding();
        test_wrap();
        test_enable_and_map();
        test_pwrbtn();
        test_events();
        test_gpe();
        test_reset_again();
        finish_run();
    end

endmodule